// File: doc/BRIEF.md
# Synchronous Sync-Hunt Byte Link

This block links a host to a serial delta-modulation codec over an unframed synchronous bit stream. Bits move on a shared bit clock, brought into the system clock domain as a one-cycle strobe `bit_en`. No start or stop bits and no parity bits are used. Character boundaries exist only because the receiver counts eight bits from the moment it finds a programmable sync character.

To start a recording, the host pulses `hunt_req`. The receiver then raises `force_idle` toward the encoder, so the line carries the alternating silence pattern, and it watches the last eight received bits. When that window equals `sync_char`, it drops `force_idle` on the very next clock and begins to assemble 8-bit characters. Completed characters are offered on a valid/ready output. If the host has not taken a character when the next one completes, the new character replaces the old one and a sticky overrun flag is set. Because `sync_char` is writable, a capture can begin on a chosen bit pattern in the signal and not only on silence.

The transmit half serializes host bytes toward the decoder on the same strobe. Whenever no host byte is waiting at a character boundary, it sends the sync character, so the line never carries undefined bits. When a run of host bytes begins, it emits a one-cycle `play_start` pulse that can trigger an external instrument.

Top module: `sync_hunt_link`

## Requirements
- R1: After reset, `force_idle`, `rx_valid`, `rx_overrun` and `play_start` are low, and the first character on `tx_bit` is `sync_char`, sent LSB first.
- R2: A one-cycle `hunt_req` raises `force_idle` on the next clock. This holds in any receiver state, including while data is being received.
- R3: Sync is declared only when the last 8 bits received since the hunt request equal `sync_char`, with the earliest of those bits compared against bit 0. Fewer than 8 bits since the hunt request never declare sync, even when `sync_char` is 8'h00.
- R4: `force_idle` falls on the clock edge that follows the bit strobe completing the sync match.
- R5: After the match, each group of 8 strobes forms one character, assembled LSB first (the first bit of the group lands in bit 0).
- R6: `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is sampled high. `rx_valid` then falls on the next clock.
- R7: If a character completes while the previous one is still unread, `rx_data` takes the new character and `rx_overrun` goes high and stays high. The next `hunt_req` clears both `rx_overrun` and `rx_valid`.
- R8: Before the first hunt request, received bits produce no characters and leave `force_idle` low.
- R9: Host bytes are sent LSB first, one bit per strobe. A byte is accepted (`tx_valid` and `tx_ready` both high at a clock edge) only on the strobe that ends the current character.
- R10: At a character boundary with no host byte offered, the transmitter sends `sync_char`.
- R11: `play_start` pulses for one clock when a host byte is accepted right after a sync fill character (or as the first character after reset), and does not pulse for bytes that follow back to back.
- R12: Without a bit strobe, `tx_bit` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per bit period of the line clock |
| sync_char | input | 8 | Programmable sync character, also used as transmit fill |
| hunt_req | input | 1 | Pulse that starts a new sync hunt |
| rx_bit | input | 1 | Serial data from the encoder, sampled on `bit_en` |
| force_idle | output | 1 | Drives the encoder to send its silence pattern while hunting |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character is available |
| rx_ready | input | 1 | Host takes the received character |
| rx_overrun | output | 1 | Sticky: an unread character was overwritten |
| tx_data | input | 8 | Host byte to transmit |
| tx_valid | input | 1 | Host byte is offered |
| tx_ready | output | 1 | Byte is accepted on this cycle |
| tx_bit | output | 1 | Serial data toward the decoder |
| play_start | output | 1 | One-cycle pulse at the start of a transmit run |

## Verification
The hardest condition to reach is a sync hunt that could match early on a window still holding bits from before the hunt request. The bench sets the sync character to all zeros and feeds zeros after the hunt request, so a window that was cleared but not counted would match at once. It then checks that `force_idle` holds through the seventh bit and falls only after the eighth. On the transmit side, the bench counts strobes from reset so that host bytes are offered at a known phase. This lets it check the exact character-by-character mix of sync fill and data.

// File: rtl/sync_link_pkg.sv
// Shared types for the sync-hunt link.
package sync_link_pkg;

    // Receiver hunt state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } hunt_state_e;

endpackage

// File: rtl/sync_hunt_rx.sv
// Receive framing for an unframed synchronous stream.
// Shifts bits in LSB first on each bit strobe. While hunting, it compares the
// window against the sync character once at least CHAR_W bits have arrived
// since the hunt request. After a match, it emits one character every CHAR_W
// strobes.
// Assumes: bit_en is a one-clock strobe, and hunt_req takes priority over bit_en.
module sync_hunt_rx
    import sync_link_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              hunt_req,
    input  logic [CHAR_W-1:0] sync_char,
    output logic              force_idle,
    output logic              byte_stb,
    output logic [CHAR_W-1:0] byte_out
);

    localparam int CNT_W  = $clog2(CHAR_W);
    localparam int FILL_W = $clog2(CHAR_W + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(CHAR_W - 1);
    localparam logic [FILL_W-1:0] FULL_M1  = FILL_W'(CHAR_W - 1);

    hunt_state_e        state;
    logic [CHAR_W-1:0]  win;
    logic [CHAR_W-1:0]  win_nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FILL_W-1:0]  fill;
    logic               match;

    // Next window: the new bit enters at the top, so the oldest bit sits in bit 0.
    assign win_nxt = {rx_bit, win[CHAR_W-1:1]};

    // Sync match: a full window of post-hunt bits that equals the programmed character.
    assign match = (fill >= FULL_M1) && (win_nxt == sync_char);

    // Hunt control, window shift and character assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            win      <= '0;
            bit_cnt  <= '0;
            fill     <= '0;
            byte_stb <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (hunt_req) begin
                state   <= ST_HUNT;
                win     <= '0;
                fill    <= '0;
                bit_cnt <= '0;
            end else if (bit_en) begin
                unique case (state)
                    ST_HUNT: begin
                        win <= win_nxt;
                        if (fill != FILL_W'(CHAR_W)) fill <= fill + 1'b1;
                        if (match) begin
                            state   <= ST_DATA;
                            bit_cnt <= '0;
                        end
                    end
                    ST_DATA: begin
                        win     <= win_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            byte_stb <= 1'b1;
                            byte_out <= win_nxt;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Encoder silence request lasts exactly as long as the hunt.
    assign force_idle = (state == ST_HUNT);

    AST_IDLE_RISE_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_idle) |-> $past(hunt_req)); // R2
    AST_IDLE_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_idle) |-> ($past(bit_en) && !$past(hunt_req))); // R4
    AST_CHAR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> ($past(bit_en) && !force_idle)); // R5

endmodule

// File: rtl/rx_byte_hold.sv
// Holding register between character assembly and the host.
// It offers each character with valid/ready. A character that arrives while the
// previous one is unread overwrites it and sets a sticky overrun flag.
// Assumes: clr (the hunt request) wins over an arriving character.
module rx_byte_hold #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic [CHAR_W-1:0] byte_in,
    input  logic              rx_ready,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overrun
);

    // Capture, hand-off and overrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (clr) begin
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (stb) begin
            rx_data  <= byte_in;
            rx_valid <= 1'b1;
            if (rx_valid && !rx_ready) rx_overrun <= 1'b1;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && rx_valid && !rx_ready && !clr) |=> rx_overrun); // R7
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !stb && !clr) |=> (rx_valid && $stable(rx_data))); // R6
    AST_VALID_FROM_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(stb)); // R5

endmodule

// File: rtl/sync_tx_ser.sv
// Transmit serializer toward the decoder.
// It sends one bit per strobe, LSB first. At each character boundary it loads the
// host byte if one is offered and otherwise loads the sync character as fill.
// It pulses play_start when a host byte follows fill.
// Assumes: sync_char is stable during reset, which loads the first character.
module sync_tx_ser #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_bit,
    output logic              play_start
);

    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

    logic [CHAR_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              in_fill;
    logic              load;

    // A new character is loaded on the strobe that ends the current one.
    assign load     = bit_en && (cnt == LAST_BIT);
    assign tx_ready = load;
    assign tx_bit   = sh[0];

    // Shift out, reload at the boundary, and track fill-to-data transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= sync_char;
            cnt        <= '0;
            in_fill    <= 1'b1;
            play_start <= 1'b0;
        end else begin
            play_start <= load && tx_valid && in_fill;
            if (load) begin
                sh      <= tx_valid ? tx_data : sync_char;
                cnt     <= '0;
                in_fill <= !tx_valid;
            end else if (bit_en) begin
                sh  <= {1'b0, sh[CHAR_W-1:1]};
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(tx_bit)); // R12
    AST_PLAY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        play_start |-> $past(tx_valid && tx_ready)); // R11
    AST_PLAY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        play_start |=> !play_start); // R11

endmodule

// File: rtl/sync_hunt_link.sv
// Top of the synchronous sync-hunt link.
// It joins the hunting receiver, the host-side holding register and the
// transmit serializer. All three run on the same bit strobe.
// Assumes: bit_en and rx_bit are already synchronized to clk.
module sync_hunt_link #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              hunt_req,
    input  logic              rx_bit,
    output logic              force_idle,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_overrun,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_bit,
    output logic              play_start
);

    logic              char_stb;
    logic [CHAR_W-1:0] char_val;

    sync_hunt_rx #(.CHAR_W(CHAR_W)) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .hunt_req   (hunt_req),
        .sync_char  (sync_char),
        .force_idle (force_idle),
        .byte_stb   (char_stb),
        .byte_out   (char_val)
    );

    rx_byte_hold #(.CHAR_W(CHAR_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (hunt_req),
        .stb        (char_stb),
        .byte_in    (char_val),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun)
    );

    sync_tx_ser #(.CHAR_W(CHAR_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .sync_char  (sync_char),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_bit     (tx_bit),
        .play_start (play_start)
    );

endmodule

// File: tb/sync_hunt_link_test.sv
// Directed bench: one task per scenario, each checking its own results.
module sync_hunt_link_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] sync_char = 8'hAA;
    logic       hunt_req = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_ready = 1'b0;
    logic       force_idle, rx_valid, rx_overrun, tx_ready, tx_bit, play_start;
    logic [7:0] rx_data;
    logic [7:0] tx_q [0:3];
    logic [2:0] tx_i = '0, tx_n = '0;
    logic       tx_valid;
    logic [7:0] tx_data;

    int checks = 0, fails = 0, nstb = 0, cap_n = 0, plays = 0;
    logic [63:0] cap;
    bit done = 1'b0;

    assign tx_valid = (tx_i != tx_n);
    assign tx_data  = tx_q[tx_i[1:0]];

    always #10 clk = ~clk;

    sync_hunt_link uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_char(sync_char),
        .hunt_req(hunt_req), .rx_bit(rx_bit), .force_idle(force_idle),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_bit(tx_bit), .play_start(play_start)
    );

    always @(negedge clk) if (rst_n && play_start) plays++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit period: capture the outgoing bit, strobe, then one idle clock.
    task automatic send_bit(input logic b);
        bit acc;
        @(negedge clk);
        cap[cap_n[5:0]] = tx_bit;
        cap_n++;
        rx_bit = b;
        bit_en = 1'b1;
        #1 acc = tx_valid && tx_ready;
        @(negedge clk);
        bit_en = 1'b0;
        nstb++;
        if (acc) tx_i = tx_i + 1'b1;
        @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk);
        hunt_req = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0;
    endtask

    task automatic take_byte(input logic [7:0] exp, input string req);
        chk(rx_valid === 1'b1, req, rx_valid, 1);
        chk(rx_data === exp, req, rx_data, exp);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(rx_valid === 1'b0, "R6 valid drops after ready", rx_valid, 0);
    endtask

    task automatic t_reset();
        chk(force_idle === 1'b0, "R1 force_idle", force_idle, 0);
        chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(rx_overrun === 1'b0, "R1 rx_overrun", rx_overrun, 0);
        chk(play_start === 1'b0, "R1 play_start", play_start, 0);
        chk(tx_bit === sync_char[0], "R1 first tx bit", tx_bit, sync_char[0]);
    endtask

    task automatic t_idle_ignore();
        logic held;
        send_char(8'hAA);
        send_char(8'h0F);
        chk(rx_valid === 1'b0, "R8 no char before hunt", rx_valid, 0);
        chk(force_idle === 1'b0, "R8 force_idle low before hunt", force_idle, 0);
        held = tx_bit;
        repeat (6) @(negedge clk);
        chk(tx_bit === held, "R12 tx_bit stable without strobe", tx_bit, held);
    endtask

    task automatic t_zero_sync_fill();
        sync_char = 8'h00;
        pulse_hunt();
        chk(force_idle === 1'b1, "R2 force_idle after hunt", force_idle, 1);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        chk(force_idle === 1'b1, "R3 no match on 7 bits", force_idle, 1);
        send_bit(1'b0);
        chk(force_idle === 1'b0, "R4 released on 8th bit", force_idle, 0);
        send_char(8'hA5);
        take_byte(8'hA5, "R5 first char LSB first");
    endtask

    task automatic t_aligned_hunt();
        sync_char = 8'hD3;
        pulse_hunt();
        chk(force_idle === 1'b1, "R2 hunt from data state", force_idle, 1);
        send_char(8'h00);
        for (int i = 0; i < 7; i++) send_bit(sync_char[i]);
        chk(force_idle === 1'b1, "R3 partial sync no match", force_idle, 1);
        send_bit(sync_char[7]);
        chk(force_idle === 1'b0, "R4 released on full sync", force_idle, 0);
        send_char(8'h12);
        repeat (5) @(negedge clk);
        chk(rx_valid === 1'b1 && rx_data === 8'h12, "R6 held without ready", rx_data, 8'h12);
        take_byte(8'h12, "R5 char after sync");
        send_char(8'h34);
        take_byte(8'h34, "R5 second char");
    endtask

    task automatic t_overrun();
        send_char(8'h55);
        chk(rx_overrun === 1'b0, "R7 no overrun yet", rx_overrun, 0);
        send_char(8'hC3);
        chk(rx_overrun === 1'b1, "R7 overrun set", rx_overrun, 1);
        take_byte(8'hC3, "R7 newest char kept");
        chk(rx_overrun === 1'b1, "R7 overrun sticky", rx_overrun, 1);
        send_char(8'h66);
        pulse_hunt();
        chk(rx_overrun === 1'b0, "R7 hunt clears overrun", rx_overrun, 0);
        chk(rx_valid === 1'b0, "R7 hunt clears valid", rx_valid, 0);
    endtask

    task automatic t_transmit();
        int p0;
        logic [7:0] c;
        logic [7:0] exp [0:3];
        while (nstb % 8 != 0) send_bit(1'b0);
        cap_n = 0;
        p0 = plays;
        tx_q[0] = 8'h3C; tx_q[1] = 8'hF0; tx_i = '0; tx_n = 3'd2;
        exp[0] = sync_char; exp[1] = 8'h3C; exp[2] = 8'hF0; exp[3] = sync_char;
        for (int i = 0; i < 32; i++) send_bit(1'b0);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 8; i++) c[i] = cap[k*8+i];
            chk(c === exp[k], k == 3 ? "R10 fill after data" : "R9 tx character", c, exp[k]);
        end
        chk(tx_i == tx_n, "R9 both bytes accepted", tx_i, tx_n);
        chk(plays - p0 == 1, "R11 one pulse per run", plays - p0, 1);
        cap_n = 0;
        tx_q[0] = 8'h81; tx_i = '0; tx_n = 3'd1;
        for (int i = 0; i < 16; i++) send_bit(1'b0);
        for (int i = 0; i < 8; i++) c[i] = cap[8+i];
        chk(c === 8'h81, "R9 byte after fill", c, 8'h81);
        chk(plays - p0 == 2, "R11 new run pulses again", plays - p0, 2);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_zero_sync_fill();
        t_aligned_hunt();
        t_overrun();
        t_transmit();
        finish_up();
    end

endmodule